// File: doc/BRIEF.md
# Two-Channel Half-Cycle Output Multiplexer

This block takes a pair of aligned 10-bit converter words, one per channel, once per sample period and places both on a single shared output bus. It runs on a clock at twice the sample rate, and an internal phase bit splits each sample period into two half-slots. Channel A's word goes onto the bus in the first half-slot. Channel B's word from the same sample goes onto the bus in the second half-slot. A flag output tells the receiver which channel the bus currently holds.

Each sample passes through a fixed delay of five sample periods before it reaches the bus. A control input selects straight offset binary or two's complement coding for the bus. A separate control turns the bus driver off; it is modelled as a registered drive-enable output. Power-down freezes the bus and the flag at their last values and discards every sample still in flight. Sleep stops new samples from being taken. After either state ends, the bus keeps its old value until a fresh sample reaches the end of the delay, and a stale-data flag marks every slot in which the bus was held.

Top module: `dual_mux_out`

## Requirements
- R1: A sample pair is taken only at a phase-0 edge (the first, third, fifth... edge after reset) while `smp_vld` is 1 and `sleep_en` is 0. Channel A's word of a sample taken at phase-0 edge k appears on `bus_q` just after phase-0 edge k+5, which is 10 fast cycles later.
- R2: Channel B's word of the same sample appears on `bus_q` just after the following phase-1 edge, one fast cycle after channel A's word.
- R3: `ab_flag` is 1 after every phase-0 edge and 0 after every phase-1 edge, unless power-down is active.
- R4: With `fmt_twos`=0 the bus carries the offset-binary word unchanged (midscale 10'h200). With `fmt_twos`=1, bit 9 is inverted and bits 8:0 are unchanged, so midscale becomes 10'h000 and 10'h000 becomes 10'h200. The format is sampled at the edge that writes the bus.
- R5: `bus_drv` equals the inverse of `out_dis` as sampled at the previous edge. `out_dis` has no effect on the value of `bus_q`.
- R6: At any edge where `pwr_dn` is 1, `bus_q` and `ab_flag` keep their values and every sample in flight is discarded.
- R7: Words presented while `sleep_en` is 1 are never placed on the bus.
- R8: `hold_flag` is 0 after an edge that writes fresh data to `bus_q` and 1 after any edge that holds the bus, including every slot after power-down or sleep until a fresh sample arrives.
- R9: After reset, `bus_q` is 0, `ab_flag` is 0, `bus_drv` is 0 and `hold_flag` is 1. The bus then holds until the first sample reaches the end of the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | An aligned sample pair is present |
| smp_a | input | 10 | Channel A word, offset binary |
| smp_b | input | 10 | Channel B word, offset binary |
| fmt_twos | input | 1 | 1 selects two's complement on the bus, 0 selects offset binary |
| out_dis | input | 1 | 1 turns the bus driver off |
| pwr_dn | input | 1 | Power-down: freeze outputs and flush samples in flight |
| sleep_en | input | 1 | Sleep: take no new samples |
| bus_q | output | 10 | Shared data bus |
| bus_drv | output | 1 | Bus drive enable (0 stands for high impedance) |
| ab_flag | output | 1 | 1 while channel A data is on the bus, 0 for channel B |
| hold_flag | output | 1 | 1 when the bus holds an old value |

## Verification
The assertions assume that the controls change only between clock edges and that reset is held across at least one edge. Both the bus-freeze and the fresh-data checks rely on the pipeline being flushed whenever power-down is sampled. The stimulus changes every input at the falling edge of the fast clock and always sends a sample pair to the block as one complete two-cycle slot that starts on a phase-0 edge, so the sample positions in the bench never drift from the block's phase bit. The power-down and sleep windows each start and end on slot boundaries. This lets the expected hold intervals be counted in whole sample periods.

// File: rtl/dual_mux_out.sv
module dual_mux_out #(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_a,
  input  logic [W-1:0] smp_b,
  input  logic         fmt_twos,
  input  logic         out_dis,
  input  logic         pwr_dn,
  input  logic         sleep_en,
  output logic [W-1:0] bus_q,
  output logic         bus_drv,
  output logic         ab_flag,
  output logic         hold_flag
);

  typedef struct packed {
    logic         v;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } slot_t;

  slot_t        pipe_q [LAT];
  logic         phase_q;
  logic [W-1:0] bwd_q;
  logic         bvld_q;
  slot_t        tail;

  assign tail = pipe_q[LAT-1];

  function automatic logic [W-1:0] recode(input logic [W-1:0] w, input logic twos);
    return twos ? {~w[W-1], w[W-2:0]} : w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) pipe_q[i] <= '0;
      phase_q   <= 1'b0;
      bwd_q     <= '0;
      bvld_q    <= 1'b0;
      bus_q     <= '0;
      bus_drv   <= 1'b0;
      ab_flag   <= 1'b0;
      hold_flag <= 1'b1;
    end else begin
      phase_q <= ~phase_q;
      bus_drv <= ~out_dis;
      if (pwr_dn) begin
        for (int i = 0; i < LAT; i++) pipe_q[i].v <= 1'b0;
        bvld_q    <= 1'b0;
        hold_flag <= 1'b1;
      end else begin
        ab_flag <= ~phase_q;
        if (!phase_q) begin
          pipe_q[0] <= '{v: smp_vld & ~sleep_en, a: smp_a, b: smp_b};
          for (int i = 1; i < LAT; i++) pipe_q[i] <= pipe_q[i-1];
          bwd_q  <= tail.b;
          bvld_q <= tail.v;
          if (tail.v) begin
            bus_q     <= recode(tail.a, fmt_twos);
            hold_flag <= 1'b0;
          end else begin
            hold_flag <= 1'b1;
          end
        end else begin
          bvld_q <= 1'b0;
          if (bvld_q) begin
            bus_q     <= recode(bwd_q, fmt_twos);
            hold_flag <= 1'b0;
          end else begin
            hold_flag <= 1'b1;
          end
        end
      end
    end
  end

  // R5
  drv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_drv == !$past(out_dis)));

  // R6
  pd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> ($stable(bus_q) && $stable(ab_flag)));

  // R8
  fresh_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_q) |-> !hold_flag);

  // R8
  stale_means_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_flag) |-> $stable(bus_q));

  // R3
  flag_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && !$past(pwr_dn) && !$past(pwr_dn, 2)) |=> (ab_flag != $past(ab_flag)));

endmodule

// File: tb/dual_mux_out_bench.sv
module dual_mux_out_bench;
  localparam int PER = 10;
  localparam int NV  = 16;

  // {fmt, a, b}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 10'h200, 10'h000}, {1'b0, 10'h3FF, 10'h001}, {1'b1, 10'h123, 10'h2DC},
    {1'b0, 10'h0AA, 10'h355}, {1'b1, 10'h200, 10'h1FF}, {1'b0, 10'h111, 10'h222},
    {1'b1, 10'h000, 10'h3FF}, {1'b1, 10'h200, 10'h201}, {1'b0, 10'h1FF, 10'h200},
    {1'b1, 10'h3FF, 10'h000}, {1'b0, 10'h0F0, 10'h30F}, {1'b1, 10'h155, 10'h2AA},
    {1'b0, 10'h001, 10'h3FE}, {1'b1, 10'h2F0, 10'h10F}, {1'b0, 10'h080, 10'h380},
    {1'b1, 10'h1C7, 10'h238}
  };

  logic clk = 0, rst_n = 0;
  logic smp_vld = 0, fmt_twos = 0, out_dis = 0, pwr_dn = 0, sleep_en = 0;
  logic [9:0] smp_a = 0, smp_b = 0;
  logic [9:0] bus_q;
  logic bus_drv, ab_flag, hold_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [9:0] sa [64], sb [64];
  int np = 0;
  logic [9:0] bA, bB;
  logic fA, fB, hA, hB, dA;

  dual_mux_out u_dual_mux_out (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_a(smp_a), .smp_b(smp_b),
    .fmt_twos(fmt_twos), .out_dis(out_dis), .pwr_dn(pwr_dn), .sleep_en(sleep_en),
    .bus_q(bus_q), .bus_drv(bus_drv), .ab_flag(ab_flag), .hold_flag(hold_flag));

  always #(PER/2) clk = ~clk;

  function automatic logic [9:0] enc(input logic [9:0] w, input logic f);
    return f ? (w ^ 10'h200) : w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one sample slot: starts and ends at a falling edge
  task automatic pair(input logic [9:0] a, input logic [9:0] b, input logic f,
                      input logic sl, input logic pd, input logic od);
    smp_vld = 1; smp_a = a; smp_b = b; fmt_twos = f;
    sleep_en = sl; pwr_dn = pd; out_dis = od;
    sa[np] = a; sb[np] = b; np++;
    @(posedge clk); #2;
    bA = bus_q; fA = ab_flag; hA = hold_flag; dA = bus_drv;
    @(posedge clk); #2;
    bB = bus_q; fB = ab_flag; hB = hold_flag;
    @(negedge clk);
  endtask

  initial begin
    #(PER*5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    repeat (3) @(negedge clk);
    chk("R9 bus reset", bus_q, 0);
    chk("R9 flag reset", ab_flag, 0);
    chk("R9 drv reset", bus_drv, 0);
    chk("R9 hold reset", hold_flag, 1);
    rst_n = 1;

    // table walk
    for (int j = 0; j < NV; j++) begin
      pair(VEC[j][19:10], VEC[j][9:0], VEC[j][20], 0, 0, 0);
      if (j < 5) begin
        chk("R9 bus holds before first sample", bA, 0);
        chk("R8 hold flag before first sample", hB, 1);
      end else begin
        chk("R1/R4 channel A word", bA, enc(VEC[j-5][19:10], VEC[j][20]));
        chk("R2/R4 channel B word", bB, enc(VEC[j-5][9:0], VEC[j][20]));
        chk("R3 flag after A", fA, 1);
        chk("R3 flag after B", fB, 0);
        chk("R8 fresh data", hA | hB, 0);
        chk("R5 driver on", dA, 1);
      end
    end

    // R5: output disable
    pair(10'h011, 10'h3EE, 0, 0, 0, 1);
    chk("R5 driver off", dA, 0);
    chk("R5 data still updates", bA, sa[np-6]);
    pair(10'h022, 10'h3DD, 0, 0, 0, 0);
    chk("R5 driver back on", dA, 1);
    chk("R5 B word", bB, sb[np-6]);

    // R6: power-down
    held = bB;
    pair(10'h033, 10'h3CC, 0, 0, 1, 0);
    chk("R6 bus frozen A slot", bA, held);
    chk("R6 bus frozen B slot", bB, held);
    chk("R6 flag frozen", fA, 0);
    chk("R8 hold in power-down", hA, 1);
    pair(10'h044, 10'h3BB, 0, 0, 1, 0);
    chk("R6 still frozen", bA, held);
    for (int k = 0; k < 5; k++) begin
      pair(10'h100 + 10'(k), 10'h2F0 - 10'(k), 0, 0, 0, 0);
      chk("R8 hold after power-down", bA, held);
      chk("R8 hold flag after power-down", hB, 1);
      chk("R3 flag resumes", fA, 1);
    end
    pair(10'h155, 10'h2AA, 0, 0, 0, 0);
    chk("R8 first fresh A after power-down", bA, 10'h100);
    chk("R8 first fresh B after power-down", bB, 10'h2F0);
    chk("R8 fresh flag", hA, 0);

    // R7: sleep
    for (int k = 0; k < 3; k++) pair(10'h1A0 + 10'(k), 10'h0A0 + 10'(k), 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      pair(10'h3A0 + 10'(k), 10'h050 + 10'(k), 0, 1, 0, 0);
      if (k == 5) held = bB;
    end
    chk("R7 last pre-sleep sample out", held, 10'h0A2);
    for (int k = 0; k < 5; k++) begin
      pair(10'h0C0 + 10'(k), 10'h1C0 + 10'(k), 0, 0, 0, 0);
      chk("R7 sleep words not shown", bA, held);
      chk("R8 hold flag after sleep", hA, 1);
    end
    pair(10'h0D0, 10'h1D0, 1, 0, 0, 0);
    chk("R7/R4 first word after sleep", bA, 10'h2C0);
    chk("R8 fresh after sleep", hA, 0);

    // R1: capture only with valid
    smp_vld = 0;
    for (int k = 0; k < 6; k++) begin
      smp_vld = 0; sleep_en = 0; pwr_dn = 0;
      @(posedge clk); #2; bA = bus_q; hA = hold_flag;
      @(posedge clk); #2; bB = bus_q;
      @(negedge clk);
    end
    chk("R1 no capture without valid", bA, bB);
    chk("R8 hold without valid", hA, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule